// File: doc/BRIEF.md
# Software Interrupt Flag Registers

This block is a byte-wide pair of I/O registers through which any bus master can raise software interrupts to a local processor. It holds four event flags: two signal flags, SIG0 and SIG1, and two location-monitor flags, LM0 and LM1. Software cannot write a flag directly. A flag changes only through write-one strobe bits in a command register: one strobe sets the flag and another clears it. An external pulse from the location-monitor comparator can also set an LM flag.

A second register, the state register, holds a read/write enable for each flag in its upper nibble. Its lower nibble shows the four flags as read-only bits. Each flag whose enable is set drives its own registered, level-sensitive, active-high interrupt output. The address comparison for the location monitor and the interrupt controller are outside this block.

Top module: `swint_flag_regs`

## Requirements
- R1: After reset, the state register reads 0x00, the command register reads 0x00, and all four interrupt outputs are 0.
- R2: State register bits 7..4 are read/write enables: bit7 enables SIG1, bit6 enables SIG0, bit5 enables LM1 and bit4 enables LM0. A write stores them and a read returns them.
- R3: State register bits 3..0 are read-only flags: bit3 SIG1, bit2 SIG0, bit1 LM1, bit0 LM0. Writes to these bits leave the flags unchanged.
- R4: Writing 1 to a command register bit sets the matching flag: bit7 sets SIG1, bit6 sets SIG0, bit5 sets LM1, bit4 sets LM0.
- R5: Writing 1 to a command register bit clears the matching flag: bit3 clears SIG1, bit2 clears SIG0, bit1 clears LM1, bit0 clears LM0.
- R6: A 0 written to any command bit leaves its flag unchanged.
- R7: When the set strobe and the clear strobe of one flag are written in the same cycle, the flag ends up set.
- R8: The command register always reads back as 0x00.
- R9: A one-cycle pulse on lm_hit[n] sets flag LMn.
- R10: irq_sig[n] and irq_lm[n] go to 1 one cycle after the matching enable and flag are both 1. While the enable is 0, the output stays 0.
- R11: An interrupt output returns to 0 one cycle after its flag or its enable is cleared.
- R12: Writes to any address other than the two register offsets (default 0x1000 command, 0x1001 state) change nothing, and reads from such an address return 0x00.
- R13: Read data appears in the cycle after the read strobe and returns to 0x00 in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| lm_hit | input | 2 | Location-monitor hit pulses, one per LM flag |
| irq_sig | output | 2 | Signal interrupts, one per SIG flag |
| irq_lm | output | 2 | Location-monitor interrupts, one per LM flag |

## Verification
A flag register stuck at a wrong value shows up in the low nibble of the next state register read, two cycles after the command write that should have changed it. With its enable set, the same fault also shows on the matching interrupt output one cycle after the write. A wrong enable or a wrong interrupt register shows on the interrupt pins within one cycle. The directed scenarios therefore read the state register after every strobe pattern. They also observe the interrupt pins both in the cycle where the output must stay unchanged and in the cycle after, which exposes off-by-one latency errors and gating errors.

// File: rtl/swf_pkg.sv
package swf_pkg;
   // flag order equals bit position in the low nibble of the state register
   localparam int FLAG_CNT = 4;
   localparam int LM_CNT   = 2;
   localparam int SIG_CNT  = FLAG_CNT - LM_CNT;
   localparam int BYTE_W   = 2 * FLAG_CNT;

   typedef enum logic [1:0] {
      F_LM0  = 2'd0,
      F_LM1  = 2'd1,
      F_SIG0 = 2'd2,
      F_SIG1 = 2'd3
   } flag_idx_e;

   typedef struct packed {
      logic [FLAG_CNT-1:0] en;
      logic [FLAG_CNT-1:0] flag;
   } state_byte_t;
endpackage

// File: rtl/swf_decode.sv
module swf_decode #(
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] CMD_ADDR  = 32'h1000,
   parameter logic [31:0] STAT_ADDR = 32'h1001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output logic              cmd_wr_o,
   output logic              stat_wr_o,
   output logic              cmd_rd_o,
   output logic              stat_rd_o
);
   localparam logic [ADDR_W-1:0] CMD_A  = CMD_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] STAT_A = STAT_ADDR[ADDR_W-1:0];

   if (CMD_A == STAT_A) begin : g_bad_map
      $error("swf_decode: command and state offsets collide");
   end

   logic hit_cmd, hit_stat;
   assign hit_cmd   = (addr_i == CMD_A);
   assign hit_stat  = (addr_i == STAT_A);
   assign cmd_wr_o  = wr_i & hit_cmd;
   assign stat_wr_o = wr_i & hit_stat;
   assign cmd_rd_o  = rd_i & hit_cmd;
   assign stat_rd_o = rd_i & hit_stat;

   // R12
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_wr_o, stat_wr_o, cmd_rd_o, stat_rd_o}) || (wr_i && rd_i));
endmodule

// File: rtl/swf_flag_cell.sv
module swf_flag_cell #(
   parameter bit HAS_HIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic hit_i,
   input  logic en_wr_i,
   input  logic en_d_i,
   output logic flag_o,
   output logic en_o,
   output logic irq_o
);
   logic flag_q, en_q, irq_q, set_any;

   if (HAS_HIT) begin : g_hit
      assign set_any = set_i | hit_i;
   end else begin : g_nohit
      logic unused_hit;
      assign unused_hit = hit_i;
      assign set_any    = set_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         en_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (set_any)    flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
         if (en_wr_i)    en_q   <= en_d_i;
         irq_q <= en_q & flag_q;
      end
   end

   assign flag_o = flag_q;
   assign en_o   = en_q;
   assign irq_o  = irq_q;

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> flag_q);
   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_any) |=> !flag_q);
   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_any && !clr_i) |=> $stable(flag_q));
   // R10
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && flag_q) |=> irq_o);
   // R11
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q || !flag_q) |=> !irq_o);
endmodule

// File: rtl/swf_readmux.sv
module swf_readmux #(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_rd_i,
   input  logic              stat_rd_i,
   input  logic [DATA_W-1:0] stat_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] sel;
   // command register strobes are not stored, so it only contributes zero
   assign sel = stat_rd_i ? stat_i : '0;

   logic unused_cmd;
   assign unused_cmd = cmd_rd_i;

   if (READ_REG) begin : g_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= sel;
      end
      assign rdata_o = rdata_q;

      // R8
      cmd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_rd_i |=> (rdata_o == '0));
      // R13
      idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !stat_rd_i |=> (rdata_o == '0));
   end else begin : g_comb
      assign rdata_o = sel;
   end
endmodule

// File: rtl/swint_flag_regs.sv
module swint_flag_regs
   import swf_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] CMD_ADDR  = 32'h1000,
   parameter logic [31:0] STAT_ADDR = 32'h1001,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic [1:0]        lm_hit,
   output logic [1:0]        irq_sig,
   output logic [1:0]        irq_lm
);
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
      $error("swint_flag_regs: ADDR_W out of range");
   end
   if (BYTE_W != 8) begin : g_bad_bw
      $error("swint_flag_regs: register byte must be 8 bits");
   end

   logic cmd_wr, stat_wr, cmd_rd, stat_rd;
   logic [FLAG_CNT-1:0] flags, ens, irqs;
   state_byte_t state_b;

   swf_decode #(
      .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr_i(io_addr), .wr_i(io_wr), .rd_i(io_rd),
      .cmd_wr_o(cmd_wr), .stat_wr_o(stat_wr), .cmd_rd_o(cmd_rd), .stat_rd_o(stat_rd)
   );

   for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
      logic hit;
      if (i < LM_CNT) begin : g_lm
         assign hit = lm_hit[i];
      end else begin : g_sig
         assign hit = 1'b0;
      end
      swf_flag_cell #(.HAS_HIT(i < LM_CNT)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .set_i(cmd_wr & io_wdata[i+FLAG_CNT]),
         .clr_i(cmd_wr & io_wdata[i]),
         .hit_i(hit),
         .en_wr_i(stat_wr),
         .en_d_i(io_wdata[i+FLAG_CNT]),
         .flag_o(flags[i]),
         .en_o(ens[i]),
         .irq_o(irqs[i])
      );
   end

   assign state_b.en   = ens;
   assign state_b.flag = flags;

   swf_readmux #(.DATA_W(BYTE_W), .READ_REG(READ_REG)) u_rd (
      .clk(clk), .rst_n(rst_n), .cmd_rd_i(cmd_rd), .stat_rd_i(stat_rd),
      .stat_i(state_b), .rdata_o(io_rdata)
   );

   assign irq_lm  = irqs[LM_CNT-1:0];
   assign irq_sig = irqs[FLAG_CNT-1:LM_CNT];

   // R3
   ro_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !cmd_wr && lm_hit == '0) |=> $stable(flags));
   // R9
   hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lm_hit[0] |=> flags[0]);
   // R2
   en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> (ens == $past(io_wdata[7:4])));
endmodule

// File: tb/test_swint_flag_regs.sv
module test_swint_flag_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [1:0]  lm_hit = '0;
   logic [1:0]  irq_sig, irq_lm;

   localparam logic [15:0] CMD  = 16'h1000;
   localparam logic [15:0] STAT = 16'h1001;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   swint_flag_regs i_swint_flag_regs (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .lm_hit(lm_hit),
      .irq_sig(irq_sig), .irq_lm(irq_lm)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 irq", {4'h0, irq_sig, irq_lm}, 8'h00);
      rd(STAT, d); chk("R1 state", d, 8'h00);
      rd(CMD, d);  chk("R1 command", d, 8'h00);
   endtask

   task automatic t_enables();
      logic [7:0] d;
      wr(STAT, 8'hA0); rd(STAT, d); chk("R2 enables A", d, 8'hA0);
      wr(STAT, 8'h5A); rd(STAT, d); chk("R3 flag bits ignored", d, 8'h50);
      wr(STAT, 8'h0F); rd(STAT, d); chk("R3 flags stay 0", d, 8'h00);
   endtask

   task automatic t_set_clear();
      logic [7:0] d;
      wr(CMD, 8'h50); rd(STAT, d); chk("R4 set SIG0 LM0", d, 8'h05);
      wr(CMD, 8'hF0); rd(STAT, d); chk("R4 set all", d, 8'h0F);
      wr(STAT, 8'h00); rd(STAT, d); chk("R3 write 0 keeps flags", d, 8'h0F);
      wr(CMD, 8'h05); rd(STAT, d); chk("R5 clear SIG0 LM0", d, 8'h0A);
      wr(CMD, 8'h00); rd(STAT, d); chk("R6 zero write", d, 8'h0A);
      wr(CMD, 8'h0A); rd(STAT, d); chk("R5 clear SIG1 LM1", d, 8'h00);
   endtask

   task automatic t_set_wins();
      logic [7:0] d;
      wr(CMD, 8'h88); rd(STAT, d); chk("R7 SIG1 set wins", d, 8'h08);
      wr(CMD, 8'hFF); rd(STAT, d); chk("R7 all set win", d, 8'h0F);
      rd(CMD, d); chk("R8 command reads 0", d, 8'h00);
      wr(CMD, 8'h0F); rd(STAT, d); chk("R5 clear all", d, 8'h00);
   endtask

   task automatic t_hit();
      logic [7:0] d;
      @(negedge clk); lm_hit = 2'b01;
      @(negedge clk); lm_hit = 2'b00;
      rd(STAT, d); chk("R9 hit LM0", d, 8'h01);
      @(negedge clk); lm_hit = 2'b10;
      @(negedge clk); lm_hit = 2'b00;
      rd(STAT, d); chk("R9 hit LM1", d, 8'h03);
      wr(CMD, 8'h0F);
   endtask

   task automatic t_irq();
      wr(CMD, 8'h80);
      @(negedge clk);
      chk("R10 gated by enable", {4'h0, irq_sig, irq_lm}, 8'h00);
      wr(STAT, 8'hF0);
      chk("R10 not yet", {4'h0, irq_sig, irq_lm}, 8'h00);
      @(negedge clk);
      chk("R10 SIG1 irq", {4'h0, irq_sig, irq_lm}, 8'h08);
      wr(STAT, 8'h70);
      chk("R11 still high", {4'h0, irq_sig, irq_lm}, 8'h08);
      @(negedge clk);
      chk("R11 enable cleared", {4'h0, irq_sig, irq_lm}, 8'h00);
      wr(STAT, 8'hF0);
      @(negedge clk);
      wr(CMD, 8'h08);
      chk("R11 flag clear lag", {4'h0, irq_sig, irq_lm}, 8'h08);
      @(negedge clk);
      chk("R11 flag cleared", {4'h0, irq_sig, irq_lm}, 8'h00);
      wr(CMD, 8'h10);
      @(negedge clk);
      chk("R10 LM0 irq", {4'h0, irq_sig, irq_lm}, 8'h01);
      wr(CMD, 8'h01);
      @(negedge clk);
      chk("R11 LM0 cleared", {4'h0, irq_sig, irq_lm}, 8'h00);
   endtask

   task automatic t_other();
      logic [7:0] d;
      wr(STAT, 8'h30);
      wr(16'h1002, 8'hFF);
      wr(16'h0000, 8'hF0);
      rd(STAT, d); chk("R12 stray writes", d, 8'h30);
      rd(16'h1002, d); chk("R12 stray read", d, 8'h00);
      rd(STAT, d);
      @(negedge clk);
      chk("R13 idle read data", io_rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enables();
      t_set_clear();
      t_set_wins();
      t_hit();
      t_irq();
      t_other();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule